// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a 4 KB window of 32-bit control and status words on a simple single-cycle request port. Byte addresses select words, so the word index is the address with its two low bits dropped. Each word belongs to one access class: read-write, read-only, write-only, unimplemented, or one of three special words. The special words are the protection key entries and a one-bit scratch flag.

A protection latch guards all ordinary stores. Software must write the release key to clear the latch before any protected write is kept. Writing the engage key sets the latch again. A key write whose low 16 bits do not match is dropped without any effect.

Any access that does not fit the class of its word is dropped and answered with an error pulse. A kept store to the reset-control word with bit 0 set also raises a one-cycle system soft-reset request.

Top module: `keybank_regs`

## Requirements
- R1: After reset the bank is protected (the protection status word reads 1). Word 0x100, 0x104 and 0x108 read 0x0001A008. Word 0x10C reads 0x0000003F. Words 0x110–0x118 read 0x00014000. Word 0x25C reads 0x00000001. The 54 pin words from 0x700 read 0x00001601, except pin indices 2 to 8, which read 0x00000601.
- R2: A write to 0x004 whose data bits [15:0] equal 0x767B sets protection. Any other value written there is dropped with no error and no change.
- R3: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears protection, whatever bits [31:16] hold. Any other value leaves protection unchanged and raises no error.
- R4: The protection status reads at 0x00C in bit 0, with all other bits zero. Address bits [1:0] are ignored on every access.
- R5: While protected, a write to a read-write or write-only word is dropped and flags an error. While unprotected, such a write is stored in full.
- R6: Word 0x000 keeps only bit 0 of the written data, reads it back in bit 0, and accepts writes even while protected.
- R7: The words at 0x004, 0x008, 0x60C and 0x614 are write-only. Reading them returns 0 with an error.
- R8: The words at 0x00C, 0x10C, 0x25C and 0x530 are read-only. A write to any of them is dropped with an error.
- R9: Any address outside the implemented set reads 0 with an error. A write to such an address flags an error and leaves nothing readable behind.
- R10: A kept write to 0x200 with data bit 0 set stores the value and pulses `soft_rst_req` for one cycle, in the response cycle. The pulse does not fire when bit 0 is clear or when the write is dropped.
- R11: Every request gets exactly one response, one cycle later. `resp_err` is high only in a response cycle, and `resp_rdata` is 0 for write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response cycle, one cycle after a request |
| resp_rdata | output | 32 | Read data (0 on error or write) |
| resp_err | output | 1 | Illegal or refused access |
| soft_rst_req | output | 1 | One-cycle system soft-reset request |

## Verification
A release-key write changes the protection latch at the same clock edge at which the next request's permission is judged. Back-to-back requests therefore let the latch update and the gating of the following write meet at one edge. The bench issues the release key and, in the very next cycle, a reset-control write with bit 0 set. It expects the soft-reset pulse with no error. It then issues the engage key immediately followed by the same write, and expects an error with no pulse.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

    localparam int DATA_W   = 32;
    localparam int KEY_W    = 16;
    localparam int PIN_CNT  = 54;

    localparam logic [KEY_W-1:0] ENGAGE_KEY  = 16'h767B;
    localparam logic [KEY_W-1:0] RELEASE_KEY = 16'hDF0D;

    // word indices (byte offset / 4)
    localparam int unsigned W_FLAG     = 'h000;
    localparam int unsigned W_ENGAGE   = 'h001;
    localparam int unsigned W_RELEASE  = 'h002;
    localparam int unsigned W_PSTAT    = 'h003;
    localparam int unsigned W_PLLC_LO  = 'h040;
    localparam int unsigned W_PLLC_HI  = 'h042;
    localparam int unsigned W_PLLSTAT  = 'h043;
    localparam int unsigned W_PLLG_LO  = 'h044;
    localparam int unsigned W_PLLG_HI  = 'h046;
    localparam int unsigned W_RSTC     = 'h080;
    localparam int unsigned W_RSTX_HI  = 'h08E;
    localparam int unsigned W_BOOT     = 'h097;
    localparam int unsigned W_IDENT    = 'h14C;
    localparam int unsigned W_CALGO    = 'h183;
    localparam int unsigned W_REFGO    = 'h185;
    localparam int unsigned W_PIN0     = 'h1C0;

    localparam logic [DATA_W-1:0] IDENT_VAL = 32'h1B2C_0001;

    typedef enum logic [2:0] {
        AC_NONE, AC_RW, AC_RO, AC_WO, AC_ENGAGE, AC_RELEASE, AC_FLAG
    } acc_e;

    typedef struct packed {
        logic              store;
        logic              err;
        logic              set_prot;
        logic              clr_prot;
        logic              rd_ok;
        logic              rd_prot;
        logic              srst;
        logic [DATA_W-1:0] wdata;
    } dec_t;

    function automatic acc_e classify(int unsigned w);
        if (w == W_FLAG)                              return AC_FLAG;
        if (w == W_ENGAGE)                            return AC_ENGAGE;
        if (w == W_RELEASE)                           return AC_RELEASE;
        if (w == W_PSTAT || w == W_PLLSTAT)           return AC_RO;
        if (w == W_BOOT || w == W_IDENT)              return AC_RO;
        if (w == W_CALGO || w == W_REFGO)             return AC_WO;
        if (w >= W_PLLC_LO && w <= W_PLLC_HI)         return AC_RW;
        if (w >= W_PLLG_LO && w <= W_PLLG_HI)         return AC_RW;
        if (w >= W_RSTC && w <= W_RSTX_HI)            return AC_RW;
        if (w >= W_PIN0 && w < W_PIN0 + PIN_CNT)      return AC_RW;
        return AC_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] reset_val(int unsigned w);
        if (w >= W_PLLC_LO && w <= W_PLLC_HI) return 32'h0001_A008;
        if (w == W_PLLSTAT)                   return 32'h0000_003F;
        if (w >= W_PLLG_LO && w <= W_PLLG_HI) return 32'h0001_4000;
        if (w == W_BOOT)                      return 32'h0000_0001;
        if (w == W_IDENT)                     return IDENT_VAL;
        if (w >= W_PIN0 && w < W_PIN0 + PIN_CNT) begin
            if (w - W_PIN0 >= 2 && w - W_PIN0 <= 8) return 32'h0000_0601;
            return 32'h0000_1601;
        end
        return '0;
    endfunction

endpackage

// File: rtl/keybank_decode.sv
module keybank_decode
    import keybank_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prot,
    output acc_e              cls,
    output dec_t              dec
);
    logic key_lo_engage, key_lo_release;

    assign cls            = classify(int'(idx));
    assign key_lo_engage  = (wdata[KEY_W-1:0] == ENGAGE_KEY);
    assign key_lo_release = (wdata[KEY_W-1:0] == RELEASE_KEY);

    always_comb begin
        dec = '0;
        dec.wdata = wdata;
        if (req_valid) begin
            unique case (cls)
                AC_FLAG: begin
                    dec.store = req_write;
                    dec.wdata = {{(DATA_W-1){1'b0}}, wdata[0]};
                    dec.rd_ok = !req_write;
                end
                AC_ENGAGE: begin
                    dec.err      = !req_write;
                    dec.set_prot = req_write && key_lo_engage;
                end
                AC_RELEASE: begin
                    dec.err      = !req_write;
                    dec.clr_prot = req_write && key_lo_release;
                end
                AC_RO: begin
                    dec.err     = req_write;
                    dec.rd_ok   = !req_write;
                    dec.rd_prot = !req_write && (int'(idx) == W_PSTAT);
                end
                AC_WO: begin
                    dec.err   = !req_write || prot;
                    dec.store = req_write && !prot;
                end
                AC_RW: begin
                    dec.err   = req_write && prot;
                    dec.store = req_write && !prot;
                    dec.rd_ok = !req_write;
                    dec.srst  = req_write && !prot && wdata[0]
                                && (int'(idx) == W_RSTC);
                end
                default: dec.err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/keybank_prot.sv
module keybank_prot (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic prot_o
);
    always_ff @(posedge clk) begin
        if (rst)        prot_o <= 1'b1;
        else if (set_i) prot_o <= 1'b1;
        else if (clr_i) prot_o <= 1'b0;
    end

    // R2 / R3: the latch moves only on an accepted key write
    p_prot_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(set_i || clr_i) |=> $stable(prot_o));
    p_prot_release_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !prot_o);
endmodule

// File: rtl/keybank_store.sv
module keybank_store
    import keybank_pkg::*;
#(
    parameter int NWORDS = 1024,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= reset_val(i);
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    // R8: the decoder never commands a store into a read-only word
    p_no_ro_store_r8: assert property (@(posedge clk) disable iff (rst)
        we |-> (classify(int'(idx)) != AC_RO));
endmodule

// File: rtl/keybank_regs.sv
module keybank_regs
    import keybank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              resp_err,
    output logic              soft_rst_req
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NWORDS = 1 << IDX_W;

    logic [IDX_W-1:0]  idx;
    logic              prot;
    acc_e              cls;
    dec_t              dec;
    logic [DATA_W-1:0] mem_rdata;

    assign idx = req_addr[ADDR_W-1:2];

    keybank_decode #(.IDX_W(IDX_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .idx       (idx),
        .wdata     (req_wdata),
        .prot      (prot),
        .cls       (cls),
        .dec       (dec)
    );

    keybank_prot u_prot (
        .clk    (clk),
        .rst    (rst),
        .set_i  (dec.set_prot),
        .clr_i  (dec.clr_prot),
        .prot_o (prot)
    );

    keybank_store #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (dec.store),
        .idx   (idx),
        .wdata (dec.wdata),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid   <= 1'b0;
            resp_rdata   <= '0;
            resp_err     <= 1'b0;
            soft_rst_req <= 1'b0;
        end else begin
            resp_valid   <= req_valid;
            resp_err     <= dec.err;
            soft_rst_req <= dec.srst;
            if (dec.rd_prot)    resp_rdata <= {{(DATA_W-1){1'b0}}, prot};
            else if (dec.rd_ok) resp_rdata <= mem_rdata;
            else                resp_rdata <= '0;
        end
    end

    // R11: fixed one-cycle response, error only alongside a response
    p_resp_latency_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);
    p_err_in_resp_r11: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> resp_valid);
    // R10: soft reset only from an unprotected, error-free write
    p_srst_clean_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst_req |-> (resp_valid && !resp_err && !$past(prot)));
    // R5: protected ordinary writes never reach storage
    p_prot_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && prot && cls == AC_RW) |-> !dec.store);
endmodule

// File: tb/keybank_regs_tb.sv
`timescale 1ns/1ps
module keybank_regs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        resp_valid, resp_err, soft_rst_req;
    logic [31:0] resp_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    keybank_regs u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .resp_err(resp_err), .soft_rst_req(soft_rst_req)
    );

    // {wr, addr, wdata, exp_rdata, exp_err, exp_srst, req}
    localparam int NV = 44;
    localparam logic [82:0] VEC [NV] = '{
        {1'b0,12'h00C,32'h0,32'h00000001,1'b0,1'b0,4'd1},   // R1 protected
        {1'b0,12'h100,32'h0,32'h0001A008,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h108,32'h0,32'h0001A008,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h10C,32'h0,32'h0000003F,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h114,32'h0,32'h00014000,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h25C,32'h0,32'h00000001,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h700,32'h0,32'h00001601,1'b0,1'b0,4'd1},   // R1
        {1'b0,12'h708,32'h0,32'h00000601,1'b0,1'b0,4'd1},   // R1 pin 2
        {1'b0,12'h720,32'h0,32'h00000601,1'b0,1'b0,4'd1},   // R1 pin 8
        {1'b0,12'h724,32'h0,32'h00001601,1'b0,1'b0,4'd1},   // R1 pin 9
        {1'b0,12'h7D4,32'h0,32'h00001601,1'b0,1'b0,4'd1},   // R1 pin 53
        {1'b1,12'h100,32'h12345678,32'h0,1'b1,1'b0,4'd5},   // R5 refused
        {1'b0,12'h100,32'h0,32'h0001A008,1'b0,1'b0,4'd5},   // R5 unchanged
        {1'b1,12'h000,32'hFFFFFFFF,32'h0,1'b0,1'b0,4'd6},   // R6 while protected
        {1'b0,12'h000,32'h0,32'h00000001,1'b0,1'b0,4'd6},   // R6 bit 0 only
        {1'b1,12'h008,32'h0000DF0C,32'h0,1'b0,1'b0,4'd3},   // R3 wrong key
        {1'b0,12'h00C,32'h0,32'h00000001,1'b0,1'b0,4'd3},   // R3 still set
        {1'b1,12'h008,32'hABCDDF0D,32'h0,1'b0,1'b0,4'd3},   // R3 key, high ignored
        {1'b0,12'h00C,32'h0,32'h00000000,1'b0,1'b0,4'd3},   // R3 cleared
        {1'b1,12'h100,32'hCAFE0001,32'h0,1'b0,1'b0,4'd5},   // R5 kept
        {1'b0,12'h100,32'h0,32'hCAFE0001,1'b0,1'b0,4'd5},   // R5
        {1'b1,12'h10C,32'h0,32'h0,1'b1,1'b0,4'd8},          // R8
        {1'b0,12'h10C,32'h0,32'h0000003F,1'b0,1'b0,4'd8},   // R8 unchanged
        {1'b1,12'h00C,32'h0,32'h0,1'b1,1'b0,4'd8},          // R8
        {1'b0,12'h00C,32'h0,32'h00000000,1'b0,1'b0,4'd8},   // R8 status kept
        {1'b1,12'h25C,32'h7,32'h0,1'b1,1'b0,4'd8},          // R8
        {1'b1,12'h530,32'h1,32'h0,1'b1,1'b0,4'd8},          // R8
        {1'b0,12'h004,32'h0,32'h0,1'b1,1'b0,4'd7},          // R7
        {1'b0,12'h008,32'h0,32'h0,1'b1,1'b0,4'd7},          // R7
        {1'b1,12'h60C,32'h5,32'h0,1'b0,1'b0,4'd7},          // R7 write ok
        {1'b0,12'h60C,32'h0,32'h0,1'b1,1'b0,4'd7},          // R7
        {1'b0,12'h614,32'h0,32'h0,1'b1,1'b0,4'd7},          // R7
        {1'b0,12'h800,32'h0,32'h0,1'b1,1'b0,4'd9},          // R9
        {1'b1,12'h800,32'h7,32'h0,1'b1,1'b0,4'd9},          // R9
        {1'b0,12'h800,32'h0,32'h0,1'b1,1'b0,4'd9},          // R9 nothing stored
        {1'b1,12'h200,32'h00000001,32'h0,1'b0,1'b1,4'd10},  // R10 pulse
        {1'b0,12'h200,32'h0,32'h00000001,1'b0,1'b0,4'd10},  // R10 stored
        {1'b1,12'h200,32'h00000002,32'h0,1'b0,1'b0,4'd10},  // R10 bit0 clear
        {1'b1,12'h004,32'h0000767A,32'h0,1'b0,1'b0,4'd2},   // R2 wrong key
        {1'b0,12'h00F,32'h0,32'h00000000,1'b0,1'b0,4'd2},   // R2 / R4 low bits
        {1'b1,12'h004,32'h5555767B,32'h0,1'b0,1'b0,4'd2},   // R2 key
        {1'b0,12'h00E,32'h0,32'h00000001,1'b0,1'b0,4'd4},   // R4 low bits
        {1'b1,12'h200,32'h00000001,32'h0,1'b1,1'b0,4'd10},  // R10 protected
        {1'b0,12'h200,32'h0,32'h00000002,1'b0,1'b0,4'd10}   // R10 unchanged
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, response is sampled one falling edge later
    task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] er, input logic ee, input logic es,
                        input int rq);
        string t;
        t = $sformatf("R%0d addr=%h", rq, a);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({t, " valid"}, {31'b0, resp_valid}, 32'h1);
        check({t, " rdata"}, resp_rdata, er);
        check({t, " err"},   {31'b0, resp_err}, {31'b0, ee});
        check({t, " srst"},  {31'b0, soft_rst_req}, {31'b0, es});
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 / R11: quiet outputs after reset
        check("R1 idle valid", {31'b0, resp_valid}, 32'h0);
        check("R1 idle srst",  {31'b0, soft_rst_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][82], VEC[i][81:70], VEC[i][69:38], VEC[i][37:6],
                 VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
        end

        // R11: no response in an idle cycle after a request
        @(negedge clk);
        check("R11 idle after req", {31'b0, resp_valid}, 32'h0);
        check("R11 idle err", {31'b0, resp_err}, 32'h0);

        // R10/R3: release key and reset-control write back to back
        xfer(1'b1, 12'h008, 32'h0000DF0D, 32'h0, 1'b0, 1'b0, 3);
        xfer(1'b1, 12'h200, 32'h00000003, 32'h0, 1'b0, 1'b1, 10);
        @(negedge clk);
        check("R10 single pulse", {31'b0, soft_rst_req}, 32'h0);
        // R2/R5: engage key then ordinary write back to back
        xfer(1'b1, 12'h004, 32'h0000767B, 32'h0, 1'b0, 1'b0, 2);
        xfer(1'b1, 12'h200, 32'h00000001, 32'h0, 1'b1, 1'b0, 5);
        xfer(1'b0, 12'h200, 32'h0, 32'h00000003, 1'b0, 1'b0, 5);

        // R1: a second reset restores protection and defaults
        xfer(1'b1, 12'h008, 32'h0000DF0D, 32'h0, 1'b0, 1'b0, 3);
        xfer(1'b1, 12'h104, 32'h0BADF00D, 32'h0, 1'b0, 1'b0, 5);
        do_reset();
        xfer(1'b0, 12'h00C, 32'h0, 32'h00000001, 1'b0, 1'b0, 1);
        xfer(1'b0, 12'h104, 32'h0, 32'h0001A008, 1'b0, 1'b0, 1);
        xfer(1'b0, 12'h000, 32'h0, 32'h00000000, 1'b0, 1'b0, 6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule